// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block produces the vertical timing of a display transcoder whose frame length can vary. A line counter runs through the visible lines and into vertical blank. Each frame then stretches to any total between a lower limit and a ceiling. The lower limit comes from the flip line and the minimum total. Software shortens a frame by posting a push. The block answers by starting the vertical-blank exit sequence at the first line the window allows. The exit sequence lasts a programmable number of lines, and the frame ends when it finishes. If no push arrives, the exit starts late enough for the frame to reach the ceiling.

Timing parameters are double buffered. Software writes pending copies through a small register port. The block copies them into the working set on a latch strobe. In variable mode the strobe coincides with the exit start. In fixed mode it fires on the vertical-blank start line. Variable mode is requested through a control bit but only takes hold, or lets go, at a frame start. A live status bit reports the mode actually in force, so software can tell when variable timing has really ended.

Top module: `vrr_vtiming`

## Requirements
- R1: While reset is held, the line count is 0, all pulse outputs are 0 and the live status reads 0. The total, minimum and flip-line registers hold the wanted line count minus one (VMAX at address 1, VMIN at 2, FLIP at 3, blank start line at 4).
- R2: When live status is 0, or when the flip-line enable (control bit 1) is 0 in the working set, every frame has exactly VMAX+1 lines. The latch strobe fires on the cycle the counter enters the blank start line.
- R3: In variable mode with no push pending, exit start fires on entering line VMAX+1-X, and the frame lasts VMAX+1 lines. The frame-start pulse fires only on line 0 and never together with exit start.
- R4: In variable mode with a push pending, exit start fires on entering the first line at or above max(FLIP+1, VMIN+2)-X and no later than VMAX+1-X. The frame then lasts exit line plus X lines.
- R5: In variable mode the latch strobe fires in the same cycle as exit start. A register write made during a frame shapes only the frames after its latch.
- R6: Control bit 2 selects the exit length X. When it is 1, X is the guard field, bits 15:8. When it is 0, X is the pipeline field (bits 23:16, 8 bits, so at most 255) plus the frame-start delay plus one. The delay is bits 25:24 plus one, giving 1 to 4.
- R7: The push register (address 5) has enable in bit 0 and send in bit 1. Send is set only by a write that has both bits 1, and it reads back as 1 until the block consumes it at an exit start.
- R8: A push write that lands in the same cycle as the consumption of the previous push survives. It reads back as pending and shortens the following frame.
- R9: Control bit 0 requests variable mode. The live status (bit 0 at address 6, and the live output) follows it only at a frame start.
- R10: A pending push is neither consumed nor able to shorten a frame while the block is in fixed mode.
- R11: The vblank output is 1 exactly when the line count is at or above the blank start line.
- R12: With the line advance input low, the line count holds and no pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_adv | input | 1 | One-cycle strobe per horizontal line |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| line_cnt | output | LINE_W | Current vertical line |
| vblank | output | 1 | Vertical blank active |
| vexit_start | output | 1 | Pulse on the first line of the blank-exit sequence |
| frame_start | output | 1 | Pulse on line 0 |
| reg_latch | output | 1 | Pulse when pending registers become active |
| vrr_live | output | 1 | Variable timing currently in force |

## Verification
Two functions can fall in the same cycle: consuming a pending push at exit start, and a new push write landing in that same cycle. The bench posts one push early in the frame so that it is consumed at the lower boundary. It then times a second push write so it lands on exactly that consumption edge. The block must report send as still set, and the next frame must be shortened to the same lower boundary. The other coincidence is exit start and latch in one cycle. It is judged by comparing the line on which each pulse appears, and by checking that a mid-frame total change alters only the following frame.

// File: rtl/vrr_vt_pkg.sv
package vrr_vt_pkg;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_VMAX = 3'd1,
        RA_VMIN = 3'd2,
        RA_FLIP = 3'd3,
        RA_VBS  = 3'd4,
        RA_PUSH = 3'd5,
        RA_STAT = 3'd6
    } reg_addr_e;

    // double-buffered part of the control word
    typedef struct packed {
        logic       flip_on;
        logic       gb_sel;
        logic [7:0] gb;
        logic [7:0] pf;
        logic [1:0] fsd;
    } ctl_t;

endpackage

// File: rtl/vrr_vt_regs.sv
module vrr_vt_regs
    import vrr_vt_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [2:0]        raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              latch_i,
    input  logic              consume_i,
    input  logic              live_i,
    output logic              en_req,
    output ctl_t              ctl_a,
    output logic [LINE_W-1:0] vmax_a,
    output logic [LINE_W-1:0] vmin_a,
    output logic [LINE_W-1:0] flip_a,
    output logic [LINE_W-1:0] vbs_a,
    output logic              push_send
);

    typedef struct packed {
        logic              on_p;
        ctl_t              ctl_p;
        logic [LINE_W-1:0] vmax_p;
        logic [LINE_W-1:0] vmin_p;
        logic [LINE_W-1:0] flip_p;
        logic [LINE_W-1:0] vbs_p;
        ctl_t              ctl_a;
        logic [LINE_W-1:0] vmax_a;
        logic [LINE_W-1:0] vmin_a;
        logic [LINE_W-1:0] flip_a;
        logic [LINE_W-1:0] vbs_a;
        logic              push_en;
        logic              push_send;
    } st_t;

    st_t  st_d, st_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (latch_i) begin
            st_d.ctl_a  = st_q.ctl_p;
            st_d.vmax_a = st_q.vmax_p;
            st_d.vmin_a = st_q.vmin_p;
            st_d.flip_a = st_q.flip_p;
            st_d.vbs_a  = st_q.vbs_p;
        end
        if (consume_i) st_d.push_send = 1'b0;
        // a write in the same cycle overrides the consumption
        if (we) begin
            case (waddr)
                RA_CTRL: begin
                    st_d.on_p          = wdata[0];
                    st_d.ctl_p.flip_on = wdata[1];
                    st_d.ctl_p.gb_sel  = wdata[2];
                    st_d.ctl_p.gb      = wdata[15:8];
                    st_d.ctl_p.pf      = wdata[23:16];
                    st_d.ctl_p.fsd     = wdata[25:24];
                end
                RA_VMAX: st_d.vmax_p = wdata[LINE_W-1:0];
                RA_VMIN: st_d.vmin_p = wdata[LINE_W-1:0];
                RA_FLIP: st_d.flip_p = wdata[LINE_W-1:0];
                RA_VBS:  st_d.vbs_p  = wdata[LINE_W-1:0];
                RA_PUSH: begin
                    st_d.push_en   = wdata[0];
                    st_d.push_send = wdata[0] & wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (raddr)
            RA_CTRL: begin
                rdata[0]     = st_q.on_p;
                rdata[1]     = st_q.ctl_p.flip_on;
                rdata[2]     = st_q.ctl_p.gb_sel;
                rdata[15:8]  = st_q.ctl_p.gb;
                rdata[23:16] = st_q.ctl_p.pf;
                rdata[25:24] = st_q.ctl_p.fsd;
            end
            RA_VMAX: rdata[LINE_W-1:0] = st_q.vmax_p;
            RA_VMIN: rdata[LINE_W-1:0] = st_q.vmin_p;
            RA_FLIP: rdata[LINE_W-1:0] = st_q.flip_p;
            RA_VBS:  rdata[LINE_W-1:0] = st_q.vbs_p;
            RA_PUSH: rdata[1:0]        = {st_q.push_send, st_q.push_en};
            RA_STAT: rdata[0]          = live_i;
            default: ;
        endcase
    end

    assign en_req    = st_q.on_p;
    assign ctl_a     = st_q.ctl_a;
    assign vmax_a    = st_q.vmax_a;
    assign vmin_a    = st_q.vmin_a;
    assign flip_a    = st_q.flip_a;
    assign vbs_a     = st_q.vbs_a;
    assign push_send = st_q.push_send;

endmodule

// File: rtl/vrr_vt_window.sv
module vrr_vt_window
    import vrr_vt_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int EW     = LINE_W + 2
) (
    input  ctl_t              ctl_a,
    input  logic [LINE_W-1:0] vmax_a,
    input  logic [LINE_W-1:0] vmin_a,
    input  logic [LINE_W-1:0] flip_a,
    output logic [EW-1:0]     xlen,
    output logic [EW-1:0]     earliest,
    output logic [EW-1:0]     latest,
    output logic              earliest_ok,
    output logic              latest_ok
);

    logic [EW-1:0] flip_cnt, vmin_lim, lo_bound, vmax_cnt;

    always_comb begin
        // delay field 0..3 means 1..4 lines, plus one fixed line
        xlen     = ctl_a.gb_sel ? EW'(ctl_a.gb)
                                : EW'(ctl_a.pf) + EW'(ctl_a.fsd) + EW'(2);
        flip_cnt = EW'(flip_a) + EW'(1);
        vmin_lim = EW'(vmin_a) + EW'(2);
        vmax_cnt = EW'(vmax_a) + EW'(1);
        lo_bound = (flip_cnt >= vmin_lim) ? flip_cnt : vmin_lim;
        earliest    = lo_bound - xlen;
        latest      = vmax_cnt - xlen;
        earliest_ok = lo_bound >= xlen;
        latest_ok   = vmax_cnt >= xlen;
    end

endmodule

// File: rtl/vrr_vt_seq.sv
module vrr_vt_seq #(
    parameter int LINE_W = 16,
    parameter int EW     = LINE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    input  logic              en_req,
    input  logic              flip_on,
    input  logic [LINE_W-1:0] vmax_a,
    input  logic [LINE_W-1:0] vbs_a,
    input  logic              push_send,
    input  logic [EW-1:0]     xlen,
    input  logic [EW-1:0]     earliest,
    input  logic [EW-1:0]     latest,
    input  logic              earliest_ok,
    input  logic              latest_ok,
    output logic [LINE_W-1:0] line,
    output logic              vblank,
    output logic              exit_start,
    output logic              frame_start,
    output logic              latch_pls,
    output logic              live,
    output logic              latch_now,
    output logic              consume
);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              exiting;
        logic [EW-1:0]     rem;
        logic              exit_p;
        logic              fs_p;
        logic              latch_p;
        logic              live;
    } st_t;

    st_t               st_d, st_q;
    logic              vrr_mode, wrap, hit_late, hit_push;
    logic [LINE_W-1:0] nxt;
    logic [EW-1:0]     nxt_w;

    always_comb begin
        st_d         = st_q;
        st_d.exit_p  = 1'b0;
        st_d.fs_p    = 1'b0;
        st_d.latch_p = 1'b0;
        consume      = 1'b0;
        vrr_mode = st_q.live & flip_on;
        wrap     = (st_q.exiting && st_q.rem <= EW'(1)) || (st_q.line == vmax_a);
        nxt      = wrap ? '0 : st_q.line + LINE_W'(1);
        nxt_w    = EW'(nxt);
        hit_late = !st_q.exiting && !wrap && latest_ok && (nxt_w == latest);
        hit_push = !st_q.exiting && !wrap && vrr_mode && push_send &&
                   earliest_ok && latest_ok && (nxt_w >= earliest) && (nxt_w <= latest);
        if (line_adv) begin
            st_d.line = nxt;
            if (wrap) begin
                st_d.exiting = 1'b0;
                st_d.rem     = '0;
                st_d.fs_p    = 1'b1;
                st_d.live    = en_req;
                st_d.latch_p = !vrr_mode && (vbs_a == '0);
            end else begin
                if (st_q.exiting) st_d.rem = st_q.rem - EW'(1);
                if (hit_late || hit_push) begin
                    st_d.exiting = 1'b1;
                    st_d.rem     = xlen;
                    st_d.exit_p  = 1'b1;
                    consume      = vrr_mode && push_send;
                end
                st_d.latch_p = vrr_mode ? (hit_late || hit_push) : (nxt == vbs_a);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line        = st_q.line;
    assign vblank      = st_q.line >= vbs_a;
    assign exit_start  = st_q.exit_p;
    assign frame_start = st_q.fs_p;
    assign latch_pls   = st_q.latch_p;
    assign live        = st_q.live;
    assign latch_now   = st_d.latch_p;

endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming
    import vrr_vt_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    input  logic              reg_we,
    input  logic [2:0]        reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [LINE_W-1:0] line_cnt,
    output logic              vblank,
    output logic              vexit_start,
    output logic              frame_start,
    output logic              reg_latch,
    output logic              vrr_live
);

    localparam int EW = LINE_W + 2;

    ctl_t              ctl_a;
    logic [LINE_W-1:0] vmax_a, vmin_a, flip_a, vbs_a;
    logic              en_req, push_send, latch_now, consume;
    logic [EW-1:0]     xlen, earliest, latest;
    logic              earliest_ok, latest_ok;

    vrr_vt_regs #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .raddr     (reg_raddr),
        .rdata     (reg_rdata),
        .latch_i   (latch_now),
        .consume_i (consume),
        .live_i    (vrr_live),
        .en_req    (en_req),
        .ctl_a     (ctl_a),
        .vmax_a    (vmax_a),
        .vmin_a    (vmin_a),
        .flip_a    (flip_a),
        .vbs_a     (vbs_a),
        .push_send (push_send)
    );

    vrr_vt_window #(.LINE_W(LINE_W), .EW(EW)) u_window (
        .ctl_a       (ctl_a),
        .vmax_a      (vmax_a),
        .vmin_a      (vmin_a),
        .flip_a      (flip_a),
        .xlen        (xlen),
        .earliest    (earliest),
        .latest      (latest),
        .earliest_ok (earliest_ok),
        .latest_ok   (latest_ok)
    );

    vrr_vt_seq #(.LINE_W(LINE_W), .EW(EW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_adv    (line_adv),
        .en_req      (en_req),
        .flip_on     (ctl_a.flip_on),
        .vmax_a      (vmax_a),
        .vbs_a       (vbs_a),
        .push_send   (push_send),
        .xlen        (xlen),
        .earliest    (earliest),
        .latest      (latest),
        .earliest_ok (earliest_ok),
        .latest_ok   (latest_ok),
        .line        (line_cnt),
        .vblank      (vblank),
        .exit_start  (vexit_start),
        .frame_start (frame_start),
        .latch_pls   (reg_latch),
        .live        (vrr_live),
        .latch_now   (latch_now),
        .consume     (consume)
    );

endmodule

// File: rtl/vrr_vt_chk.sv
module vrr_vt_chk
    import vrr_vt_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_waddr,
    input logic [LINE_W-1:0] line_cnt,
    input logic              vexit_start,
    input logic              frame_start,
    input logic              reg_latch,
    input logic              vrr_live,
    input logic              flip_on,
    input logic              push_send
);

    // R3
    fs_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (line_cnt == '0));

    // R3
    fs_exit_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !vexit_start);

    // R9
    live_at_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vrr_live != $past(vrr_live)) |-> frame_start);

    // R7
    send_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(push_send) |-> (vexit_start || $past(reg_we && reg_waddr == RA_PUSH)));

    // R5
    latch_with_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vexit_start && $past(vrr_live) && $past(flip_on)) |-> reg_latch);

endmodule

bind vrr_vtiming vrr_vt_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_waddr   (reg_waddr),
    .line_cnt    (line_cnt),
    .vexit_start (vexit_start),
    .frame_start (frame_start),
    .reg_latch   (reg_latch),
    .vrr_live    (vrr_live),
    .flip_on     (ctl_a.flip_on),
    .push_send   (push_send)
);

// File: tb/vrr_vtiming_bench.sv
module vrr_vtiming_bench;
    import vrr_vt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 16;
    localparam int DW = 32;

    typedef struct packed {
        int gbs; int xv; int fsd; int fon;
        int vmin; int flip; int vmax; int push;
        int ex; int len; int lat; int pushrd;
    } vec_t;

    // counts are real line counts; registers get count-1
    localparam vec_t VT [7] = '{
        '{1, 3, 0, 1, 10, 11, 20, -1, 17, 20, 17, 1},  // R3 no push
        '{1, 3, 0, 1, 10, 11, 20,  2,  8, 11,  8, 1},  // R4 early push
        '{1, 3, 0, 1, 10, 11, 20, 10, 12, 15, 12, 1},  // R4 mid push
        '{0, 2, 1, 1, 10, 12, 24,  9, 11, 16, 11, 1},  // R6 legacy X=5
        '{0, 1, 3, 1, 14, 12, 22,  0,  9, 15,  9, 1},  // R4 R6 vmin clamp X=6
        '{1, 3, 0, 0, 10, 11, 18,  2, 15, 18,  6, 3},  // R10 flip off
        '{1, 3, 0, 1, 10, 11, 20, 15, 17, 20, 17, 1}   // R4 late push
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_adv = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_waddr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [2:0]    reg_raddr = '0;
    logic [DW-1:0] reg_rdata;
    logic [LW-1:0] line_cnt;
    logic          vblank, vexit_start, frame_start, reg_latch, vrr_live;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vrr_vtiming #(.LINE_W(LW), .DATA_W(DW)) u_vrr_vtiming (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_adv    (line_adv),
        .reg_we      (reg_we),
        .reg_waddr   (reg_waddr),
        .reg_wdata   (reg_wdata),
        .reg_raddr   (reg_raddr),
        .reg_rdata   (reg_rdata),
        .line_cnt    (line_cnt),
        .vblank      (vblank),
        .vexit_start (vexit_start),
        .frame_start (frame_start),
        .reg_latch   (reg_latch),
        .vrr_live    (vrr_live)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        reg_we    = 1'b1;
        reg_waddr = 3'(addr);
        reg_wdata = DW'(data);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int addr, output int val);
        reg_raddr = 3'(addr);
        #1;
        val = int'(reg_rdata);
    endtask

    task automatic wait_fs();
        do @(negedge clk); while (!frame_start);
    endtask

    function automatic int ctrl_word(input int on, input int fon, input int gbs,
                                     input int xv, input int fsd);
        return on | (fon << 1) | (gbs << 2) | (gbs != 0 ? (xv << 8) : (xv << 16)) | (fsd << 24);
    endfunction

    task automatic cfg(input int on, input int fon, input int gbs, input int xv, input int fsd,
                       input int vmin, input int flip, input int vmax, input int vbs);
        wr(RA_CTRL, ctrl_word(on, fon, gbs, xv, fsd));
        wr(RA_VMIN, vmin - 1);
        wr(RA_FLIP, flip - 1);
        wr(RA_VMAX, vmax - 1);
        wr(RA_VBS, vbs);
        wait_fs(); wait_fs(); wait_fs();
    endtask

    // starts at a negedge showing frame_start, ends at the next one
    task automatic run_frame(input int la, input int aa, input int da,
                             input int lb, input int ab, input int db,
                             output int ex_line, output int lat_line, output int len);
        ex_line = -1; lat_line = -1; len = 0;
        do begin
            if (int'(line_cnt) == la) begin
                reg_we = 1'b1; reg_waddr = 3'(aa); reg_wdata = DW'(da);
            end else if (int'(line_cnt) == lb) begin
                reg_we = 1'b1; reg_waddr = 3'(ab); reg_wdata = DW'(db);
            end else begin
                reg_we = 1'b0;
            end
            if (vexit_start) ex_line = int'(line_cnt);
            if (reg_latch) lat_line = int'(line_cnt);
            len++;
            @(negedge clk);
        end while (!frame_start);
        reg_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int ex, lat, len, v, ln;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 line in reset", int'(line_cnt), 0);
        chk("R1 fs in reset", int'(frame_start), 0);
        chk("R1 exit in reset", int'(vexit_start), 0);
        chk("R1 latch in reset", int'(reg_latch), 0);
        chk("R1 live in reset", int'(vrr_live), 0);
        rd(RA_PUSH, v); chk("R1 push reg in reset", v, 0);
        rd(RA_STAT, v); chk("R1 status in reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 fixed mode, variable timing not requested; pending push
        wr(RA_PUSH, 3);
        cfg(0, 1, 1, 3, 0, 10, 11, 16, 9);
        run_frame(-1, 0, 0, -1, 0, 0, ex, lat, len);
        chk("R2 fixed frame length", len, 16);
        chk("R2 latch at blank start", lat, 9);
        chk("R1 R2 live stays off", int'(vrr_live), 0);
        // R11 vblank over a whole frame
        for (int i = 0; i < 16; i++) begin
            chk("R11 vblank vs line", int'(vblank), int'(line_cnt >= 16'd9));
            @(negedge clk);
        end
        rd(RA_PUSH, v); chk("R10 push kept while fixed", v, 3);
        wr(RA_PUSH, 2);
        rd(RA_PUSH, v); chk("R7 send without enable ignored", v, 0);
        wr(RA_PUSH, 1);

        // table of configurations
        for (int k = 0; k < 7; k++) begin
            cfg(1, VT[k].fon, VT[k].gbs, VT[k].xv, VT[k].fsd,
                VT[k].vmin, VT[k].flip, VT[k].vmax, 6);
            chk("R9 live after enable", int'(vrr_live), 1);
            run_frame(VT[k].push, RA_PUSH, 3, -1, 0, 0, ex, lat, len);
            chk("R3 R4 exit line", ex, VT[k].ex);
            chk("R3 R4 R6 frame length", len, VT[k].len);
            chk("R2 R5 latch line", lat, VT[k].lat);
            rd(RA_PUSH, v); chk("R7 R10 push readback", v, VT[k].pushrd);
            wr(RA_PUSH, 1);
            wait_fs();
        end

        // R8 second push landing on the consumption edge
        cfg(1, 1, 1, 3, 0, 10, 11, 20, 6);
        run_frame(2, RA_PUSH, 3, 7, RA_PUSH, 3, ex, lat, len);
        chk("R8 first exit", ex, 8);
        chk("R8 first length", len, 11);
        rd(RA_PUSH, v); chk("R8 new push survives", v, 3);
        run_frame(-1, 0, 0, -1, 0, 0, ex, lat, len);
        chk("R8 second frame shortened", len, 11);
        rd(RA_PUSH, v); chk("R7 push consumed", v, 1);

        // R5 double buffering of the total
        run_frame(3, RA_VMAX, 29, -1, 0, 0, ex, lat, len);
        chk("R5 current frame unchanged", len, 20);
        chk("R5 latch at exit", lat, 17);
        run_frame(-1, 0, 0, -1, 0, 0, ex, lat, len);
        chk("R5 next frame uses new total", len, 30);
        chk("R3 exit with new total", ex, 27);

        // R9 disable waits for a frame boundary
        wr(RA_CTRL, ctrl_word(0, 1, 1, 3, 0));
        rd(RA_STAT, v); chk("R9 status still live", v, 1);
        chk("R9 live port still set", int'(vrr_live), 1);
        wait_fs();
        rd(RA_STAT, v); chk("R9 status cleared at frame start", v, 0);
        run_frame(2, RA_PUSH, 3, -1, 0, 0, ex, lat, len);
        chk("R2 R10 fixed length ignores push", len, 30);
        chk("R2 latch at blank start", lat, 6);
        rd(RA_PUSH, v); chk("R10 push not consumed", v, 3);

        // R12 stall
        @(negedge clk);
        ln = int'(line_cnt);
        line_adv = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R12 no pulse while stalled", int'(frame_start | vexit_start | reg_latch), 0);
        end
        chk("R12 line held", int'(line_cnt), ln);
        line_adv = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule